// File: doc/BRIEF.md
# Master-Mode Audio Serial Clock Generator

This block produces the serial bit clock and the left/right frame clock of an audio serial link when the local converter owns the link timing. Both clocks are derived from the master clock by counting master-clock cycles. There is no second clock domain. The outputs are registered levels plus single-cycle strobes that mark bit-clock edges and frame starts, so downstream serialisers can run on the master clock.

A 3-bit ratio field picks a prescale of 1, 1.5, 2, 3 or 4. A 2-bit speed field picks single, double or quad rate, which sets how far the prescaled clock is divided. The frame clock always runs at the sample rate. The bit clock always makes 64 periods per frame.

Internally the two fields collapse into one half-bit interval, measured in master cycles. A phase counter turns that interval into enable pulses. A half-bit counter turns the enables into the bit clock and the frame clock. Every change of the mode fields restarts both counters.

Top module: `audio_clk_gen`

## Requirements
- R1: While `rst_ni` is low, every output is 0.
- R2: For a valid configuration, the bit-clock period in master cycles is the prescale × bit divide, where:
  - the ratio codes map 0→1, 1→1.5, 2→2, 3→3 and 4→4;
  - the speed codes map 0→4, 1→2 and 2→1.
- R3: For a valid configuration, the frame-clock period is the prescale × 256, 128 or 64 master cycles for speed codes 0, 1 or 2. Frame-clock low marks the left half.
- R4: Each frame holds exactly 64 bit-clock rising edges, and the frame clock is high for the second 32 bits.
- R5: When the half-bit interval is 1.5 master cycles, the half-bit enables follow a 3-cycle pattern of enable, enable, idle. The resulting bit-clock high level lasts 1 cycle and the low level lasts 2 cycles.
- R6: Ratio codes 5–7 and speed code 3 are reserved. From the first edge that samples such a code, `cfg_err_o` is 1 and all other outputs are 0.
- R7: Quad speed (code 2) with ratio code 0 or 1 needs a half-bit interval below one master cycle. This combination is treated as reserved, exactly as in R6.
- R8: A master-clock edge that samples changed mode fields clears both counters. After that edge:
  - the bit clock and frame clock are low;
  - the first bit-clock rise follows one edge later, on the next enable.
- R9: The frame clock changes only on the same edge where the bit clock falls, apart from the restart in R8.
- R10: The strobes behave as follows:
  - `bclk_rise_o` is high in exactly the cycles in which `bclk_o` has just gone high;
  - `bclk_fall_o` is high in exactly the cycles in which `bclk_o` has just gone low;
  - `frame_start_o` is high in exactly the cycles in which the frame clock has just returned low after a full frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ratio_i | input | 3 | Master-clock prescale select |
| speed_i | input | 2 | Speed mode select |
| bclk_o | output | 1 | Serial bit clock |
| lrck_o | output | 1 | Frame clock, low = left |
| bclk_rise_o | output | 1 | Strobe: bit clock just rose |
| bclk_fall_o | output | 1 | Strobe: bit clock just fell |
| frame_start_o | output | 1 | Strobe: new frame (left) started |
| cfg_err_o | output | 1 | Reserved configuration selected |

## Verification
Every one of the 32 ratio/speed combinations is applied after a reserved setting, and each valid one runs for two full frames. Every sampled cycle is compared against an arithmetic count of the half-bit enables expected since the restart.

The integer intervals confirm the divider arithmetic for each speed. The 1.5-cycle intervals separate the uneven enable pattern from a plain rounding to 1 or 2. The reserved and quad-overspeed settings show that the error path, rather than the counters, drives the outputs.

Two direct changes from one valid setting to another, made in the middle of a frame, show that the restart does not depend on the counter state left behind.

// File: rtl/acg_pkg.sv
package acg_pkg;
  localparam int PERIOD_W = 4;

  typedef enum logic [2:0] {
    RATIO_DIV1   = 3'd0,
    RATIO_DIV1P5 = 3'd1,
    RATIO_DIV2   = 3'd2,
    RATIO_DIV3   = 3'd3,
    RATIO_DIV4   = 3'd4
  } ratio_e;

  typedef enum logic [1:0] {
    SPD_SINGLE = 2'd0,
    SPD_DOUBLE = 2'd1,
    SPD_QUAD   = 2'd2
  } speed_e;

  // half-bit interval: period master cycles, or 2 enables per period cycles when frac
  typedef struct packed {
    logic                err;
    logic                frac;
    logic [PERIOD_W-1:0] period;
  } rate_t;
endpackage

// File: rtl/acg_rate_dec.sv
module acg_rate_dec
  import acg_pkg::*;
(
  input  logic [2:0] ratio_i,
  input  logic [1:0] speed_i,
  output rate_t      rate_o
);
  logic [5:0] pre2;   // prescale x2
  logic [5:0] bdiv;
  logic [5:0] num;    // 2 x half-bit interval, x2 again
  logic [4:0] half2;  // 2 x half-bit interval
  logic       bad;

  always_comb begin
    bad = 1'b0;
    unique case (ratio_i)
      RATIO_DIV1:   pre2 = 6'd2;
      RATIO_DIV1P5: pre2 = 6'd3;
      RATIO_DIV2:   pre2 = 6'd4;
      RATIO_DIV3:   pre2 = 6'd6;
      RATIO_DIV4:   pre2 = 6'd8;
      default: begin
        pre2 = 6'd2;
        bad  = 1'b1;
      end
    endcase
    unique case (speed_i)
      SPD_SINGLE: bdiv = 6'd4;
      SPD_DOUBLE: bdiv = 6'd2;
      SPD_QUAD:   bdiv = 6'd1;
      default: begin
        bdiv = 6'd4;
        bad  = 1'b1;
      end
    endcase
  end

  assign num   = pre2 * bdiv;
  assign half2 = num[5:1];

  always_comb begin
    rate_o = '0;
    if (bad || num[0] || half2 == 5'd1) begin
      rate_o.err = 1'b1;
    end else if (half2[0]) begin
      rate_o.frac   = 1'b1;
      rate_o.period = half2[PERIOD_W-1:0];
    end else begin
      rate_o.period = half2[PERIOD_W:1];
    end
  end
endmodule

// File: rtl/acg_tick_gen.sv
module acg_tick_gen
  import acg_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clear_i,
  input  rate_t rate_i,
  output logic  tick_o
);
  logic [PERIOD_W-1:0] ph_q;
  logic [PERIOD_W:0]   ph_nxt;
  logic                last;

  assign ph_nxt = {1'b0, ph_q} + 1'b1;
  assign last   = ph_nxt >= {1'b0, rate_i.period};

  // fractional: two enables per period, at phase 0 and mid-phase
  assign tick_o = !rate_i.err &&
                  (ph_q == '0 || (rate_i.frac && ph_q == (rate_i.period >> 1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ph_q <= '0;
    else if (clear_i) ph_q <= '0;
    else if (last)    ph_q <= '0;
    else              ph_q <= ph_nxt[PERIOD_W-1:0];
  end
endmodule

// File: rtl/acg_frame_div.sv
module acg_frame_div #(
  parameter int HC_W = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic tick_i,
  output logic bclk_o,
  output logic lrck_o,
  output logic rise_o,
  output logic fall_o,
  output logic frame_o
);
  logic [HC_W-1:0] hc_q;
  logic            rise_q, fall_q, frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hc_q    <= '0;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
      frame_q <= 1'b0;
    end else if (clear_i) begin
      hc_q    <= '0;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
      frame_q <= 1'b0;
    end else begin
      rise_q  <= tick_i && !hc_q[0];
      fall_q  <= tick_i && hc_q[0];
      frame_q <= tick_i && (&hc_q);
      if (tick_i) hc_q <= hc_q + 1'b1;
    end
  end

  // frame MSB flips only when bit 0 wraps 1->0, i.e. on a bit-clock fall
  assign bclk_o  = hc_q[0];
  assign lrck_o  = hc_q[HC_W-1];
  assign rise_o  = rise_q;
  assign fall_o  = fall_q;
  assign frame_o = frame_q;
endmodule

// File: rtl/audio_clk_gen.sv
module audio_clk_gen
  import acg_pkg::*;
#(
  parameter int FRAME_BITS = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] ratio_i,
  input  logic [1:0] speed_i,
  output logic       bclk_o,
  output logic       lrck_o,
  output logic       bclk_rise_o,
  output logic       bclk_fall_o,
  output logic       frame_start_o,
  output logic       cfg_err_o
);
  localparam int HALF_BITS = 2 * FRAME_BITS;
  localparam int HC_W      = $clog2(HALF_BITS);

  logic [4:0] cfg_q;
  logic       resync;
  logic       clear;
  logic       tick;
  logic       err_q;
  rate_t      rate;

  acg_rate_dec u_dec (
    .ratio_i (ratio_i),
    .speed_i (speed_i),
    .rate_o  (rate)
  );

  assign resync = {ratio_i, speed_i} != cfg_q;
  assign clear  = resync || rate.err;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      err_q <= 1'b0;
    end else begin
      cfg_q <= {ratio_i, speed_i};
      err_q <= rate.err;
    end
  end

  acg_tick_gen u_tick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .rate_i  (rate),
    .tick_o  (tick)
  );

  acg_frame_div #(.HC_W(HC_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .tick_i  (tick),
    .bclk_o  (bclk_o),
    .lrck_o  (lrck_o),
    .rise_o  (bclk_rise_o),
    .fall_o  (bclk_fall_o),
    .frame_o (frame_start_o)
  );

  assign cfg_err_o = err_q;
endmodule

// File: rtl/acg_chk.sv
module acg_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] ratio_i,
  input logic [1:0] speed_i,
  input logic       bclk_o,
  input logic       lrck_o,
  input logic       bclk_rise_o,
  input logic       bclk_fall_o,
  input logic       frame_start_o,
  input logic       cfg_err_o
);
  // R9
  lrck_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((lrck_o != $past(lrck_o)) && $past(ratio_i) == $past(ratio_i, 2) &&
     $past(speed_i) == $past(speed_i, 2)) |-> ($past(bclk_o) && !bclk_o));

  // R6
  err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> (!bclk_o && !lrck_o && !bclk_rise_o && !bclk_fall_o && !frame_start_o));

  // R8
  restart_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ratio_i) != $past(ratio_i, 2) || $past(speed_i) != $past(speed_i, 2))
      |-> (!bclk_o && !lrck_o));

  // R10
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({bclk_rise_o, bclk_fall_o}));

  // R10
  rise_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bclk_rise_o |-> (bclk_o && !$past(bclk_o)));

  // R10
  fall_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bclk_fall_o |-> (!bclk_o && $past(bclk_o)));

  // R10
  frame_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> (bclk_fall_o && !lrck_o && $past(lrck_o)));
endmodule

bind audio_clk_gen acg_chk u_chk (.*);

// File: tb/audio_clk_gen_tb.sv
module audio_clk_gen_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [2:0] ratio_i;
  logic [1:0] speed_i;
  logic       bclk_o, lrck_o, bclk_rise_o, bclk_fall_o, frame_start_o, cfg_err_o;

  int n_run  = 0;
  int n_fail = 0;

  always #10 clk_i = ~clk_i;

  audio_clk_gen u_dut (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ratio_i       (ratio_i),
    .speed_i       (speed_i),
    .bclk_o        (bclk_o),
    .lrck_o        (lrck_o),
    .bclk_rise_o   (bclk_rise_o),
    .bclk_fall_o   (bclk_fall_o),
    .frame_start_o (frame_start_o),
    .cfg_err_o     (cfg_err_o)
  );

  function automatic bit cfg_bad(int r, int s);
    return (r > 4) || (s > 2) || (s == 2 && r < 2);
  endfunction

  // twice the half-bit interval, in master cycles
  function automatic int half2(int r, int s);
    int pre2;
    case (r)
      0: pre2 = 2;
      1: pre2 = 3;
      2: pre2 = 4;
      3: pre2 = 6;
      default: pre2 = 8;
    endcase
    return pre2 * (4 >> s) / 2;
  endfunction

  // enables in cycles 1..m after a restart
  function automatic int n_events(int d2, int m);
    if (d2 % 2 == 0) return (m + d2 / 2 - 1) / (d2 / 2);
    return (m / 3) * 2 + (((m % 3) > 2) ? 2 : (m % 3));
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (ratio %0d speed %0d)",
               req, what, act, exp, ratio_i, speed_i);
    end
  endtask

  task automatic run_cfg(int r, int s, int n, string tag);
    bit    bad;
    int    d2, hc, prev_hc, rises;
    bit    exp_b, exp_l, prev_b, prev_l;
    string rb;
    @(negedge clk_i);
    ratio_i = 3'(r);
    speed_i = 2'(s);
    bad     = cfg_bad(r, s);
    d2      = bad ? 0 : half2(r, s);
    if (bad) rb = (s == 2 && r < 2) ? "R7" : "R6";
    else     rb = (d2 == 3) ? "R5" : "R2";
    prev_hc = 0;
    prev_b  = 0;
    prev_l  = 0;
    rises   = 0;
    for (int m = 0; m < n; m++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      hc    = bad ? 0 : n_events(d2, m) % 128;
      exp_b = hc[0];
      exp_l = hc >= 64;
      chk((m == 0) ? tag : rb, "bclk", bclk_o, exp_b);
      chk((m == 0) ? tag : "R3", "lrck", lrck_o, exp_l);
      chk(bad ? rb : "R6", "err", cfg_err_o, bad);
      chk("R10", "rise", bclk_rise_o, (m > 0) && exp_b && !prev_hc[0]);
      chk("R10", "fall", bclk_fall_o, (m > 0) && !exp_b && prev_hc[0]);
      chk("R10", "frame", frame_start_o, (m > 0) && hc == 0 && prev_hc == 127);
      if (m > 0 && lrck_o != prev_l)
        chk("R9", "bclk fell with lrck", int'(prev_b && !bclk_o), 1);
      if (frame_start_o) begin
        chk("R4", "rises per frame", rises, 64);
        rises = 0;
      end
      if (bclk_rise_o) rises++;
      prev_hc = hc;
      prev_b  = bclk_o;
      prev_l  = lrck_o;
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL all: watchdog, actual hung expected done");
    finish_run();
  end

  initial begin
    rst_ni  = 1'b0;
    ratio_i = 3'd0;
    speed_i = 2'd0;
    // R1
    repeat (4) begin
      @(negedge clk_i);
      chk("R1", "reset outs",
          {bclk_o, lrck_o, bclk_rise_o, bclk_fall_o, frame_start_o, cfg_err_o}, 0);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;

    // full sweep; R6 and R7 cover reserved combos
    for (int r = 0; r < 8; r++) begin
      for (int s = 0; s < 4; s++) begin
        run_cfg(7, 3, 4, "R6");
        if (cfg_bad(r, s)) run_cfg(r, s, 6, "R8");
        else               run_cfg(r, s, 128 * half2(r, s) + 8, "R8");
      end
    end

    // R8: valid-to-valid change in mid frame
    run_cfg(2, 0, 300, "R2");
    run_cfg(3, 1, 128 * half2(3, 1) + 8, "R8");
    run_cfg(4, 0, 777, "R2");
    run_cfg(1, 1, 128 * half2(1, 1) + 8, "R8");
    finish_run();
  end
endmodule